// File: doc/BRIEF.md
# Receive Serial Frame Timing Engine

This block recovers frame position on one serial time-division receive port. The port supplies a bit clock, a data line and a frame-sync line. The engine works in the system clock domain and oversamples the port's bit clock. On each active edge of that clock it samples data and sync together. A software-chosen setting decides whether the rising or the falling edge is active. A low-to-high change on the sampled sync line marks bit 0 of a frame. From that point the engine counts bits into 8-bit time slots and delivers each finished slot byte with its slot number and a one-cycle strobe.

Three framings are supported. T1 has one framing bit followed by 24 slots. E1 has 32 slots. Nx64 has a configurable number of slots, from 1 to 32. In none of these modes is there an offset between the sync edge and frame bit 0. The framing bit of T1 goes out on a strobe of its own. With flywheel tracking enabled, the engine starts each following frame by itself. If a sync edge then arrives where no frame start is due, the engine realigns and reports it. With flywheel tracking disabled, every frame waits for a fresh sync edge.

Top module: `rx_frame_timing`

## Requirements
- R1: When `cfg_fall_edge` is 0, data and sync are sampled on the rising edge of `rx_clk`. When it is 1, they are sampled on the falling edge. A sampled bit produces its outputs one system clock after the system clock edge at which the active edge is first seen.
- R2: A sampled sync value of 1 following a sampled 0 marks frame bit 0 and restarts slot counting. A sync line held high for several bits starts only one frame.
- R3: With `cfg_mode` = 0 (T1), frame bit 0 is the framing bit. It appears on `fbit_data` with a one-cycle `fbit_valid` and belongs to no slot. The following 192 bits form slots 0 to 23, for a frame of 193 bits.
- R4: With `cfg_mode` = 1 (E1), frame bit 0 is the most significant bit of slot 0, and a frame holds slots 0 to 31 (256 bits).
- R5: With `cfg_mode` = 2 (Nx64), a frame holds `cfg_last_slot`+1 slots, and frame bit 0 is the most significant bit of slot 0, with no added delay.
- R6: Slot bits are assembled first-received-as-MSB. Each completed byte appears on `slot_data` with its index on `slot_index` and a `slot_valid` pulse one system clock wide.
- R7: With `cfg_flywheel` = 1, the bit after the last slot of a frame begins a new frame without any sync edge.
- R8: With `cfg_flywheel` = 0, bits after the end of a frame, and bits before the first sync edge after reset, produce no outputs until a new sync edge arrives.
- R9: With `cfg_flywheel` = 1, a sync edge arriving anywhere other than at the expected frame start pulses `align_err`, drops the partly filled byte and restarts the frame at that bit. A sync edge that arrives exactly at the expected start raises no error.
- R10: After reset, every strobe output is 0 and no bits are taken until a sync edge arrives.
- R11: `frame_start` pulses once for every frame bit 0, whether that bit comes from a sync edge or from flywheel tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_clk | input | 1 | Serial bit clock of the port, already synchronous to `clk` |
| rx_data | input | 1 | Serial data line |
| rx_sync | input | 1 | Frame sync line |
| cfg_fall_edge | input | 1 | 0: sample on rising edge, 1: on falling edge |
| cfg_mode | input | 2 | 0 T1, 1 E1, 2 Nx64 (3 treated as Nx64) |
| cfg_last_slot | input | SLOT_W | Nx64 slot count minus one |
| cfg_flywheel | input | 1 | Enable internal tracking of frame starts |
| slot_valid | output | 1 | One-cycle strobe for a completed slot byte |
| slot_data | output | SLOT_BITS | Completed slot byte, MSB first received |
| slot_index | output | SLOT_W | Slot number of that byte |
| fbit_valid | output | 1 | One-cycle strobe for the T1 framing bit |
| fbit_data | output | 1 | Value of the T1 framing bit |
| frame_start | output | 1 | One-cycle pulse on frame bit 0 |
| align_err | output | 1 | One-cycle pulse on a misplaced sync edge in flywheel mode |

## Verification
Flywheel wrap-around and a fresh sync edge can land on the same sampled bit. The bench provokes this by sending a sync edge exactly one frame length after the previous start, and holds sync high across several bits. It then expects one frame start, no `align_err` and correct slot bytes. The opposite case is a sync edge five bits into slot 1 of an Nx64 frame. There the bench expects one `align_err`, no byte for the broken slot, and a fresh slot 0 built from the bit that carried the edge.

// File: rtl/rx_frame_timing_pkg.sv
`timescale 1ns/1ps
package rx_frame_timing_pkg;
    typedef enum logic [1:0] {
        FMT_T1   = 2'd0,
        FMT_E1   = 2'd1,
        FMT_NX64 = 2'd2
    } frame_fmt_e;
endpackage

// File: rtl/rft_edge_pick.sv
`timescale 1ns/1ps
module rft_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic fall_sel,
    output logic bit_tick
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d    = ser_clk;
        bit_tick = fall_sel ? (lvl_q & ~ser_clk) : (~lvl_q & ser_clk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/rft_sync_rise.sv
`timescale 1ns/1ps
module rft_sync_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic sync_in,
    output logic sync_edge
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d    = bit_tick ? sync_in : prev_q;
        sync_edge = bit_tick & sync_in & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rft_framer.sv
`timescale 1ns/1ps
module rft_framer
    import rx_frame_timing_pkg::*;
#(
    parameter  int SLOT_BITS = 8,
    parameter  int MAX_SLOTS = 32,
    parameter  int T1_SLOTS  = 24,
    parameter  int E1_SLOTS  = 32,
    localparam int SLOT_W    = $clog2(MAX_SLOTS),
    localparam int CNT_W     = $clog2(SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 sync_edge,
    input  logic                 bit_in,
    input  logic [1:0]           mode,
    input  logic [SLOT_W-1:0]    last_nx,
    input  logic                 flywheel,
    output logic                 o_slot_vld,
    output logic [SLOT_BITS-1:0] o_slot_dat,
    output logic [SLOT_W-1:0]    o_slot_idx,
    output logic                 o_fbit_vld,
    output logic                 o_fbit_dat,
    output logic                 o_fstart,
    output logic                 o_aerr
);
    typedef struct packed {
        logic                 active;
        logic                 wrap;
        logic [SLOT_W-1:0]    slot;
        logic [CNT_W-1:0]     cnt;
        logic [SLOT_BITS-1:0] shift;
        logic                 slot_vld;
        logic [SLOT_BITS-1:0] slot_dat;
        logic [SLOT_W-1:0]    slot_idx;
        logic                 fbit_vld;
        logic                 fbit_dat;
        logic                 fstart;
        logic                 aerr;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic [SLOT_W-1:0]    last_slot;
    logic [SLOT_BITS-1:0] merged;
    logic                 begin_frame;
    logic                 take_bit;

    always_comb begin
        st_d          = st_q;
        st_d.slot_vld = 1'b0;
        st_d.fbit_vld = 1'b0;
        st_d.fstart   = 1'b0;
        st_d.aerr     = 1'b0;
        take_bit      = 1'b0;
        merged        = '0;

        case (frame_fmt_e'(mode))
            FMT_T1:  last_slot = SLOT_W'(T1_SLOTS - 1);
            FMT_E1:  last_slot = SLOT_W'(E1_SLOTS - 1);
            default: last_slot = last_nx;
        endcase

        begin_frame = sync_edge | (st_q.active & st_q.wrap & flywheel);

        if (bit_tick) begin
            if (sync_edge && st_q.active && flywheel && !st_q.wrap)
                st_d.aerr = 1'b1;

            if (begin_frame) begin
                st_d.fstart = 1'b1;
                st_d.active = 1'b1;
                st_d.wrap   = 1'b0;
                st_d.slot   = '0;
                st_d.cnt    = '0;
                st_d.shift  = '0;
                if (frame_fmt_e'(mode) == FMT_T1) begin
                    st_d.fbit_vld = 1'b1;
                    st_d.fbit_dat = bit_in;
                end else begin
                    take_bit = 1'b1;
                end
            end else if (st_q.active && !st_q.wrap) begin
                take_bit = 1'b1;
            end else begin
                st_d.active = 1'b0;
            end

            if (take_bit) begin
                merged = {st_d.shift[SLOT_BITS-2:0], bit_in};
                if (st_d.cnt == CNT_W'(SLOT_BITS - 1)) begin
                    st_d.slot_vld = 1'b1;
                    st_d.slot_dat = merged;
                    st_d.slot_idx = st_d.slot;
                    st_d.cnt      = '0;
                    st_d.shift    = '0;
                    if (st_d.slot == last_slot) st_d.wrap = 1'b1;
                    else                        st_d.slot = st_d.slot + 1'b1;
                end else begin
                    st_d.cnt   = st_d.cnt + 1'b1;
                    st_d.shift = merged;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign o_slot_vld = st_q.slot_vld;
    assign o_slot_dat = st_q.slot_dat;
    assign o_slot_idx = st_q.slot_idx;
    assign o_fbit_vld = st_q.fbit_vld;
    assign o_fbit_dat = st_q.fbit_dat;
    assign o_fstart   = st_q.fstart;
    assign o_aerr     = st_q.aerr;
endmodule

// File: rtl/rx_frame_timing.sv
`timescale 1ns/1ps
module rx_frame_timing #(
    parameter  int SLOT_BITS = 8,
    parameter  int MAX_SLOTS = 32,
    parameter  int T1_SLOTS  = 24,
    parameter  int E1_SLOTS  = 32,
    localparam int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_clk,
    input  logic                 rx_data,
    input  logic                 rx_sync,
    input  logic                 cfg_fall_edge,
    input  logic [1:0]           cfg_mode,
    input  logic [SLOT_W-1:0]    cfg_last_slot,
    input  logic                 cfg_flywheel,
    output logic                 slot_valid,
    output logic [SLOT_BITS-1:0] slot_data,
    output logic [SLOT_W-1:0]    slot_index,
    output logic                 fbit_valid,
    output logic                 fbit_data,
    output logic                 frame_start,
    output logic                 align_err
);
    logic bit_tick;
    logic sync_edge;

    rft_edge_pick u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (rx_clk),
        .fall_sel (cfg_fall_edge),
        .bit_tick (bit_tick)
    );

    rft_sync_rise u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .sync_in   (rx_sync),
        .sync_edge (sync_edge)
    );

    rft_framer #(
        .SLOT_BITS (SLOT_BITS),
        .MAX_SLOTS (MAX_SLOTS),
        .T1_SLOTS  (T1_SLOTS),
        .E1_SLOTS  (E1_SLOTS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .sync_edge  (sync_edge),
        .bit_in     (rx_data),
        .mode       (cfg_mode),
        .last_nx    (cfg_last_slot),
        .flywheel   (cfg_flywheel),
        .o_slot_vld (slot_valid),
        .o_slot_dat (slot_data),
        .o_slot_idx (slot_index),
        .o_fbit_vld (fbit_valid),
        .o_fbit_dat (fbit_data),
        .o_fstart   (frame_start),
        .o_aerr     (align_err)
    );
endmodule

// File: rtl/rx_frame_timing_chk.sv
`timescale 1ns/1ps
module rx_frame_timing_chk #(
    parameter  int MAX_SLOTS = 32,
    parameter  int T1_SLOTS  = 24,
    localparam int SLOT_W    = $clog2(MAX_SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [SLOT_W-1:0] cfg_last_slot,
    input logic              cfg_flywheel,
    input logic              slot_valid,
    input logic [SLOT_W-1:0] slot_index,
    input logic              fbit_valid,
    input logic              frame_start,
    input logic              align_err
);
    a_r3_fbit_not_slot: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_valid |-> !slot_valid);

    a_r3_fbit_t1_only: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_valid |-> cfg_mode == 2'd0);

    a_r3_t1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cfg_mode == 2'd0) |-> slot_index < SLOT_W'(T1_SLOTS));

    a_r5_nx_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && cfg_mode == 2'd2) |-> slot_index <= cfg_last_slot);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |=> !slot_valid);

    a_r9_err_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (frame_start && cfg_flywheel));

    a_r11_fbit_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_valid |-> frame_start);
endmodule

bind rx_frame_timing rx_frame_timing_chk #(
    .MAX_SLOTS (MAX_SLOTS),
    .T1_SLOTS  (T1_SLOTS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_last_slot (cfg_last_slot),
    .cfg_flywheel  (cfg_flywheel),
    .slot_valid    (slot_valid),
    .slot_index    (slot_index),
    .fbit_valid    (fbit_valid),
    .frame_start   (frame_start),
    .align_err     (align_err)
);

// File: tb/rx_frame_timing_tb.sv
`timescale 1ns/1ps
module rx_frame_timing_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       rx_data = 1'b0;
    logic       rx_sync = 1'b0;
    logic       cfg_fall_edge = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [4:0] cfg_last_slot = 5'd0;
    logic       cfg_flywheel = 1'b0;
    logic       slot_valid;
    logic [7:0] slot_data;
    logic [4:0] slot_index;
    logic       fbit_valid;
    logic       fbit_data;
    logic       frame_start;
    logic       align_err;

    int checks = 0;
    int fails  = 0;
    int nbytes = 0;
    int nfbit  = 0;
    int nfs    = 0;
    int nae    = 0;
    logic       last_fbit = 1'b0;
    logic [7:0] cap_data [0:511];
    logic [4:0] cap_slot [0:511];

    always #4 clk = ~clk;

    rx_frame_timing u_dut (
        .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data),
        .rx_sync(rx_sync), .cfg_fall_edge(cfg_fall_edge), .cfg_mode(cfg_mode),
        .cfg_last_slot(cfg_last_slot), .cfg_flywheel(cfg_flywheel),
        .slot_valid(slot_valid), .slot_data(slot_data), .slot_index(slot_index),
        .fbit_valid(fbit_valid), .fbit_data(fbit_data),
        .frame_start(frame_start), .align_err(align_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (slot_valid) begin
                cap_data[nbytes] = slot_data;
                cap_slot[nbytes] = slot_index;
                nbytes = nbytes + 1;
            end
            if (fbit_valid) begin
                nfbit = nfbit + 1;
                last_fbit = fbit_data;
            end
            if (frame_start) nfs = nfs + 1;
            if (align_err)   nae = nae + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int k);
        return 8'((seed * 37 + k * 11 + 5) ^ (k << 3));
    endfunction

    task automatic apply_reset(input logic [1:0] md, input bit fly,
                               input bit fall, input logic [4:0] last);
        rst_n = 1'b0; rx_clk = 1'b0; rx_sync = 1'b0; rx_data = 1'b0;
        cfg_mode = md; cfg_flywheel = fly; cfg_fall_edge = fall;
        cfg_last_slot = last;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // The non-active edge always sees the inverted data bit.
    task automatic send_bit(input logic d, input logic s);
        rx_sync = s;
        rx_data = cfg_fall_edge ? ~d : d;
        repeat (2) @(negedge clk);
        rx_clk = 1'b1;
        repeat (2) @(negedge clk);
        rx_data = cfg_fall_edge ? d : ~d;
        @(negedge clk);
        rx_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input bit t1, input logic fv, input int seed,
                              input int sync_bits, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            logic d;
            int   j;
            if (t1 && i == 0) d = fv;
            else begin
                j = t1 ? i - 1 : i;
                d = byte_of(seed, j / 8)[7 - (j % 8)];
            end
            send_bit(d, (i < sync_bits) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic check_bytes(input int base, input int nsl, input int seed,
                               input string req);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int k = 0; k < nsl; k++) begin
            if (cap_data[base + k] != byte_of(seed, k) || cap_slot[base + k] != 5'(k)) begin
                if (bad == 0) begin
                    first_act = int'(cap_data[base + k]);
                    first_exp = int'(byte_of(seed, k));
                end
                bad++;
            end
        end
        chk(bad == 0, req, "slot bytes and indices", first_act, first_exp);
    endtask

    task automatic t_reset_state();
        apply_reset(2'd1, 1'b0, 1'b0, 5'd0);
        chk(!slot_valid && !fbit_valid && !frame_start && !align_err, "R10",
            "strobes after reset", int'({slot_valid, fbit_valid, frame_start, align_err}), 0);
    endtask

    task automatic t_t1_single();
        int b0;
        apply_reset(2'd0, 1'b0, 1'b0, 5'd0);
        b0 = nbytes;
        send_frame(1'b0, 1'b0, 9, 0, 5);
        chk(nbytes == b0 && nfs == 0, "R8", "bits before first sync", nbytes - b0, 0);
        send_frame(1'b1, 1'b1, 3, 1, 193);
        chk(nbytes - b0 == 24, "R3", "T1 slot count", nbytes - b0, 24);
        check_bytes(b0, 24, 3, "R6");
        chk(nfbit == 1 && last_fbit == 1'b1, "R3", "T1 framing bit", nfbit, 1);
        chk(nfs == 1, "R11", "frame start pulses", nfs, 1);
        chk(cap_data[b0] == byte_of(3, 0), "R1", "rising edge sample", int'(cap_data[b0]), int'(byte_of(3, 0)));
        send_frame(1'b0, 1'b0, 4, 0, 16);
        chk(nbytes - b0 == 24 && nfs == 1, "R8", "bits after frame end", nbytes - b0, 24);
    endtask

    task automatic t_e1_flywheel();
        int b0;
        int f0;
        apply_reset(2'd1, 1'b1, 1'b0, 5'd0);
        b0 = nbytes; f0 = nfs;
        send_frame(1'b0, 1'b0, 5, 1, 256);
        check_bytes(b0, 32, 5, "R4");
        send_frame(1'b0, 1'b0, 6, 0, 256);
        chk(nbytes - b0 == 64, "R7", "byte count across tracked frame", nbytes - b0, 64);
        check_bytes(b0 + 32, 32, 6, "R7");
        // On-time sync coinciding with wrap, held high for four bits.
        send_frame(1'b0, 1'b0, 7, 4, 256);
        chk(nae == 0, "R9", "on-time sync raises no error", nae, 0);
        chk(nfs - f0 == 3, "R2", "held sync gives one start", nfs - f0, 3);
        check_bytes(b0 + 64, 32, 7, "R2");
    endtask

    task automatic t_nx_realign();
        int b0;
        apply_reset(2'd2, 1'b1, 1'b1, 5'd3);
        b0 = nbytes;
        send_frame(1'b0, 1'b0, 11, 1, 32);
        chk(nbytes - b0 == 4, "R5", "Nx64 slot count", nbytes - b0, 4);
        check_bytes(b0, 4, 11, "R1");
        send_frame(1'b0, 1'b0, 12, 0, 13);
        chk(nbytes - b0 == 5 && cap_data[b0 + 4] == byte_of(12, 0), "R7",
            "tracked slot 0 before realign", nbytes - b0, 5);
        send_frame(1'b0, 1'b0, 13, 1, 32);
        chk(nae == 1, "R9", "misplaced sync error", nae, 1);
        chk(nbytes - b0 == 9, "R9", "partial byte dropped", nbytes - b0, 9);
        check_bytes(b0 + 5, 4, 13, "R9");
    endtask

    initial begin
        #1200000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_t1_single();
        t_e1_flywheel();
        t_nx_realign();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule